// File: doc/BRIEF.md
# Keyboard Controller Command Processor

This block is the host-facing front end of a PC-style keyboard and pointing-device controller. The host reaches it through one byte-wide bus. A select input chooses between a command port and a data port, and separate read and write strobes qualify each access. A byte written to the command port is decoded at once. It may edit the mode byte, emit a one-byte controller reply toward the output-buffer logic, drive the output port (and with it the address-line-20 gate and a system reset request), or arm a two-phase command. An armed command waits for the next data-port write and then consumes that byte.

Downstream logic sits behind plain one-cycle byte-valid strobes: the reply strobe to the output-buffer arbiter, and the transmit strobes toward the keyboard and auxiliary serial channels. The arbiter, serial signalling and scan-code translation live elsewhere. A command-port read returns the status byte on the following cycle.

The sequencing is a state machine with six states. ST_IDLE means no command is armed. In that state a data write goes to the keyboard channel. ST_LOAD_MODE (armed by 0x60), ST_LOAD_PORT (0xD1), ST_KBD_REPLY (0xD2), ST_AUX_REPLY (0xD3) and ST_AUX_FWD (0xD4) each wait for one data write. The transitions are as follows. A command write of any arming byte moves from any state to the state that byte names. A data write moves from any state back to ST_IDLE. Every other access keeps the state.

Top module: `kbc_cmd_engine`

## Requirements
- R1: After reset the mode byte is 0x03, the status byte is 0x18, the output port is 0xCF, the A20 output is 1, and no strobe or reset pulse is active.
- R2: Commands that reply raise reply_valid_o for exactly one cycle, on the cycle after the write, with reply_aux_o = 0. The reply byte is: the mode byte for 0x20; 0x55 for 0xAA, which also sets status bit 2; 0x00 for 0xA9 and 0xAB; 0x80 for 0xC0; the output-port value for 0xD0.
- R3: 0xA7 sets mode bit 5 (aux disable) and 0xA8 clears it. 0xAD sets mode bit 4 (keyboard disable) and 0xAE clears it.
- R4: Writing 0x60, 0xD1, 0xD2, 0xD3 or 0xD4 changes no output; it only arms that command. A later arming command replaces the armed one. Non-arming commands leave the armed command in place. The next data write is consumed by the armed command, and after it the block is unarmed again.
- R5: Armed 0x60 loads the data byte into the mode byte. Armed 0xD1 loads it into the output port, with A20 following bit 1. If bit 0 of that byte is 0, sys_reset_o pulses for one cycle.
- R6: Armed 0xD2 emits the data byte as a reply with reply_aux_o = 0. Armed 0xD3 emits it with reply_aux_o = 1.
- R7: Armed 0xD4 sends the data byte on the aux transmit strobe and clears mode bit 5. An unarmed data write sends it on the keyboard transmit strobe and clears mode bit 4.
- R8: A command with upper nibble 0xF gives a one-cycle sys_reset_o pulse when bit 0 is 0 and does nothing when bit 0 is 1. The output port is unchanged in both cases.
- R9: 0xDF sets output-port bit 1 and A20 to 1. 0xDD clears both.
- R10: A command byte not listed above changes no mode, output-port, status or arm state and produces no strobe.
- R11: Status bit 3 is 1 after a command write and 0 after a data write. A read with the command port selected returns the status byte on host_rdata on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_sel | input | 1 | Port select: 1 command/status, 0 data |
| host_wr | input | 1 | Write strobe |
| host_rd | input | 1 | Read strobe |
| host_wdata | input | 8 | Write byte |
| host_rdata | output | 8 | Status byte captured by a command-port read |
| mode_o | output | 8 | Current mode byte |
| outport_o | output | 8 | Current output port |
| a20_o | output | 1 | Address-line-20 gate (output-port bit 1) |
| sys_reset_o | output | 1 | One-cycle system reset request |
| reply_valid_o | output | 1 | Controller reply strobe |
| reply_data_o | output | 8 | Controller reply byte |
| reply_aux_o | output | 1 | Reply is aux-sourced |
| kbd_tx_valid_o | output | 1 | Keyboard transmit strobe |
| kbd_tx_data_o | output | 8 | Keyboard transmit byte |
| aux_tx_valid_o | output | 1 | Aux transmit strobe |
| aux_tx_data_o | output | 8 | Aux transmit byte |

## Verification
The assertions assume the host raises only one strobe per cycle and that reset is held for at least one clock. They also take it that every pulse traces back to a write in the previous cycle. The stimulus meets this by driving each access for a single cycle from the falling edge and then returning all strobes to zero. It never combines a read with a write. A stretch of random command and data bytes, compared every clock against a behavioural model, covers arm overrides and unrecognised bytes without breaking these rules.

// File: rtl/kbc_pkg.sv
package kbc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD_MODE,
        ST_LOAD_PORT,
        ST_KBD_REPLY,
        ST_AUX_REPLY,
        ST_AUX_FWD
    } arm_state_t;

    typedef enum logic [1:0] {
        RP_CONST,
        RP_MODE,
        RP_PORT
    } reply_src_t;

    typedef struct packed {
        logic       reply_en;
        reply_src_t reply_src;
        logic [7:0] reply_const;
        logic       arm_en;
        arm_state_t arm_state;
        logic [7:0] mode_set;
        logic [7:0] mode_clr;
        logic       a20_set;
        logic       a20_clr;
        logic       pulse_rst;
        logic       selftest;
    } cmd_dec_t;

    typedef struct packed {
        logic load_mode;
        logic load_port;
        logic kbd_reply;
        logic aux_reply;
        logic aux_fwd;
        logic kbd_fwd;
    } data_act_t;

endpackage

// File: rtl/kbc_cmd_decode.sv
module kbc_cmd_decode
    import kbc_pkg::*;
#(
    parameter int         KBD_OFF_BIT    = 4,
    parameter int         AUX_OFF_BIT    = 5,
    parameter logic [7:0] SELFTEST_REPLY = 8'h55,
    parameter logic [7:0] INPORT_VALUE   = 8'h80
) (
    input  logic [7:0] cmd,
    output cmd_dec_t   dec
);
    localparam logic [7:0] KBD_MASK = 8'(1) << KBD_OFF_BIT;
    localparam logic [7:0] AUX_MASK = 8'(1) << AUX_OFF_BIT;

    always_comb begin
        dec           = '0;
        dec.reply_src = RP_CONST;
        dec.arm_state = ST_IDLE;
        if (cmd[7:4] == 4'hF) begin
            // whole top range folds into pulse-or-nothing
            dec.pulse_rst = ~cmd[0];
        end else begin
            case (cmd)
                8'h20: begin dec.reply_en = 1'b1; dec.reply_src = RP_MODE; end
                8'h60: begin dec.arm_en = 1'b1; dec.arm_state = ST_LOAD_MODE; end
                8'hD1: begin dec.arm_en = 1'b1; dec.arm_state = ST_LOAD_PORT; end
                8'hD2: begin dec.arm_en = 1'b1; dec.arm_state = ST_KBD_REPLY; end
                8'hD3: begin dec.arm_en = 1'b1; dec.arm_state = ST_AUX_REPLY; end
                8'hD4: begin dec.arm_en = 1'b1; dec.arm_state = ST_AUX_FWD; end
                8'hA7: dec.mode_set = AUX_MASK;
                8'hA8: dec.mode_clr = AUX_MASK;
                8'hAD: dec.mode_set = KBD_MASK;
                8'hAE: dec.mode_clr = KBD_MASK;
                8'hA9, 8'hAB: dec.reply_en = 1'b1;
                8'hAA: begin
                    dec.reply_en    = 1'b1;
                    dec.reply_const = SELFTEST_REPLY;
                    dec.selftest    = 1'b1;
                end
                8'hC0: begin dec.reply_en = 1'b1; dec.reply_const = INPORT_VALUE; end
                8'hD0: begin dec.reply_en = 1'b1; dec.reply_src = RP_PORT; end
                8'hDF: dec.a20_set = 1'b1;
                8'hDD: dec.a20_clr = 1'b1;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/kbc_arm_fsm.sv
module kbc_arm_fsm
    import kbc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_wr,
    input  logic       data_wr,
    input  logic       arm_en,
    input  arm_state_t arm_target,
    output arm_state_t state,
    output data_act_t  act
);
    arm_state_t state_nx;

    always_comb begin
        state_nx = state;
        if (cmd_wr && arm_en)
            state_nx = arm_target;
        else if (data_wr)
            state_nx = ST_IDLE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // data-phase action selected by the armed state
    always_comb begin
        act = '0;
        if (data_wr) begin
            unique case (state)
                ST_IDLE:      act.kbd_fwd   = 1'b1;
                ST_LOAD_MODE: act.load_mode = 1'b1;
                ST_LOAD_PORT: act.load_port = 1'b1;
                ST_KBD_REPLY: act.kbd_reply = 1'b1;
                ST_AUX_REPLY: act.aux_reply = 1'b1;
                ST_AUX_FWD:   act.aux_fwd   = 1'b1;
                default:      act.kbd_fwd   = 1'b1;
            endcase
        end
    end

    // R4
    arm_consumed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && !cmd_wr) |=> (state == ST_IDLE));

    // R4
    arm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!data_wr && !(cmd_wr && arm_en)) |=> $stable(state));

endmodule

// File: rtl/kbc_cmd_engine.sv
module kbc_cmd_engine
    import kbc_pkg::*;
#(
    parameter logic [7:0] MODE_RST       = 8'h03,
    parameter logic [7:0] STATUS_RST     = 8'h18,
    parameter logic [7:0] OUTPORT_RST    = 8'hCF,
    parameter logic [7:0] SELFTEST_REPLY = 8'h55,
    parameter logic [7:0] INPORT_VALUE   = 8'h80,
    parameter int         KBD_OFF_BIT    = 4,
    parameter int         AUX_OFF_BIT    = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       host_sel,
    input  logic       host_wr,
    input  logic       host_rd,
    input  logic [7:0] host_wdata,
    output logic [7:0] host_rdata,
    output logic [7:0] mode_o,
    output logic [7:0] outport_o,
    output logic       a20_o,
    output logic       sys_reset_o,
    output logic       reply_valid_o,
    output logic [7:0] reply_data_o,
    output logic       reply_aux_o,
    output logic       kbd_tx_valid_o,
    output logic [7:0] kbd_tx_data_o,
    output logic       aux_tx_valid_o,
    output logic [7:0] aux_tx_data_o
);
    localparam int ST_SELFTEST_BIT = 2;
    localparam int ST_CMDLAST_BIT  = 3;
    localparam int PORT_RST_BIT    = 0;
    localparam int PORT_A20_BIT    = 1;

    logic       cmd_wr, data_wr;
    cmd_dec_t   dec;
    arm_state_t state;
    data_act_t  act;
    logic [7:0] mode_q, port_q, status_q;
    logic [7:0] reply_byte;

    assign cmd_wr  = host_wr &  host_sel;
    assign data_wr = host_wr & ~host_sel;

    kbc_cmd_decode #(
        .KBD_OFF_BIT   (KBD_OFF_BIT),
        .AUX_OFF_BIT   (AUX_OFF_BIT),
        .SELFTEST_REPLY(SELFTEST_REPLY),
        .INPORT_VALUE  (INPORT_VALUE)
    ) u_dec (
        .cmd(host_wdata),
        .dec(dec)
    );

    kbc_arm_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_wr    (cmd_wr),
        .data_wr   (data_wr),
        .arm_en    (dec.arm_en),
        .arm_target(dec.arm_state),
        .state     (state),
        .act       (act)
    );

    always_comb begin
        unique case (dec.reply_src)
            RP_MODE:  reply_byte = mode_q;
            RP_PORT:  reply_byte = port_q;
            default:  reply_byte = dec.reply_const;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q         <= MODE_RST;
            port_q         <= OUTPORT_RST;
            status_q       <= STATUS_RST;
            host_rdata     <= '0;
            sys_reset_o    <= 1'b0;
            reply_valid_o  <= 1'b0;
            reply_data_o   <= '0;
            reply_aux_o    <= 1'b0;
            kbd_tx_valid_o <= 1'b0;
            kbd_tx_data_o  <= '0;
            aux_tx_valid_o <= 1'b0;
            aux_tx_data_o  <= '0;
        end else begin
            sys_reset_o    <= 1'b0;
            reply_valid_o  <= 1'b0;
            kbd_tx_valid_o <= 1'b0;
            aux_tx_valid_o <= 1'b0;
            if (host_rd && host_sel)
                host_rdata <= status_q;
            if (cmd_wr) begin
                status_q[ST_CMDLAST_BIT] <= 1'b1;
                if (dec.selftest)
                    status_q[ST_SELFTEST_BIT] <= 1'b1;
                mode_q <= (mode_q | dec.mode_set) & ~dec.mode_clr;
                if (dec.a20_set) port_q[PORT_A20_BIT] <= 1'b1;
                if (dec.a20_clr) port_q[PORT_A20_BIT] <= 1'b0;
                sys_reset_o <= dec.pulse_rst;
                if (dec.reply_en) begin
                    reply_valid_o <= 1'b1;
                    reply_data_o  <= reply_byte;
                    reply_aux_o   <= 1'b0;
                end
            end
            if (data_wr) begin
                status_q[ST_CMDLAST_BIT] <= 1'b0;
                if (act.load_mode)
                    mode_q <= host_wdata;
                if (act.load_port) begin
                    port_q      <= host_wdata;
                    sys_reset_o <= ~host_wdata[PORT_RST_BIT];
                end
                if (act.kbd_reply || act.aux_reply) begin
                    reply_valid_o <= 1'b1;
                    reply_data_o  <= host_wdata;
                    reply_aux_o   <= act.aux_reply;
                end
                if (act.kbd_fwd) begin
                    kbd_tx_valid_o      <= 1'b1;
                    kbd_tx_data_o       <= host_wdata;
                    mode_q[KBD_OFF_BIT] <= 1'b0;
                end
                if (act.aux_fwd) begin
                    aux_tx_valid_o      <= 1'b1;
                    aux_tx_data_o       <= host_wdata;
                    mode_q[AUX_OFF_BIT] <= 1'b0;
                end
            end
        end
    end

    assign mode_o    = mode_q;
    assign outport_o = port_q;
    assign a20_o     = port_q[PORT_A20_BIT];

    // R5
    rst_from_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sys_reset_o |-> $past(host_wr));

    // R2
    reply_from_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reply_valid_o |-> $past(host_wr));

    // R7
    kbd_enabled_on_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        kbd_tx_valid_o |-> !mode_o[KBD_OFF_BIT]);

    // R7
    aux_enabled_on_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        aux_tx_valid_o |-> !mode_o[AUX_OFF_BIT]);

    // R6
    one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({reply_valid_o, kbd_tx_valid_o, aux_tx_valid_o}));

    // R2
    selftest_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(status_q[ST_SELFTEST_BIT]) |-> status_q[ST_SELFTEST_BIT]);

    // R8
    port_only_by_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(host_wr) |-> $stable(outport_o));

endmodule

// File: tb/kbc_cmd_engine_tb.sv
module kbc_cmd_engine_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_sel = 1'b0, host_wr = 1'b0, host_rd = 1'b0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata, mode_o, outport_o, reply_data_o, kbd_tx_data_o, aux_tx_data_o;
    logic       a20_o, sys_reset_o, reply_valid_o, reply_aux_o, kbd_tx_valid_o, aux_tx_valid_o;

    int n_chk = 0, n_fail = 0;
    bit cmp_on = 1'b0;

    always #10 clk = ~clk;

    kbc_cmd_engine u_dut (
        .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
        .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .mode_o(mode_o), .outport_o(outport_o), .a20_o(a20_o),
        .sys_reset_o(sys_reset_o), .reply_valid_o(reply_valid_o),
        .reply_data_o(reply_data_o), .reply_aux_o(reply_aux_o),
        .kbd_tx_valid_o(kbd_tx_valid_o), .kbd_tx_data_o(kbd_tx_data_o),
        .aux_tx_valid_o(aux_tx_valid_o), .aux_tx_data_o(aux_tx_data_o)
    );

    // behavioural reference
    int m_mode, m_port, m_stat, m_arm, m_rdata;
    int m_rst, m_rv, m_rd, m_ra, m_kv, m_kd, m_av, m_ad;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 'h03; m_port = 'hCF; m_stat = 'h18; m_arm = 0; m_rdata = 0;
            m_rst = 0; m_rv = 0; m_rd = 0; m_ra = 0; m_kv = 0; m_kd = 0; m_av = 0; m_ad = 0;
        end else begin
            int b;
            b = host_wdata;
            m_rst = 0; m_rv = 0; m_kv = 0; m_av = 0;
            if (host_rd && host_sel) m_rdata = m_stat;
            if (host_wr && host_sel) begin
                m_stat = m_stat | 'h08;
                if ((b / 16) == 15) begin
                    if (b % 2 == 0) m_rst = 1;
                end else begin
                    case (b)
                        'h20: begin m_rv = 1; m_rd = m_mode; m_ra = 0; end
                        'h60, 'hD1, 'hD2, 'hD3, 'hD4: m_arm = b;
                        'hA7: m_mode = m_mode | 'h20;
                        'hA8: m_mode = m_mode & 'hDF;
                        'hAD: m_mode = m_mode | 'h10;
                        'hAE: m_mode = m_mode & 'hEF;
                        'hA9, 'hAB: begin m_rv = 1; m_rd = 0; m_ra = 0; end
                        'hAA: begin m_stat = m_stat | 'h04; m_rv = 1; m_rd = 'h55; m_ra = 0; end
                        'hC0: begin m_rv = 1; m_rd = 'h80; m_ra = 0; end
                        'hD0: begin m_rv = 1; m_rd = m_port; m_ra = 0; end
                        'hDF: m_port = m_port | 'h02;
                        'hDD: m_port = m_port & 'hFD;
                        default: ;
                    endcase
                end
            end
            if (host_wr && !host_sel) begin
                m_stat = m_stat & 'hF7;
                case (m_arm)
                    'h60: m_mode = b;
                    'hD1: begin m_port = b; if (b % 2 == 0) m_rst = 1; end
                    'hD2: begin m_rv = 1; m_rd = b; m_ra = 0; end
                    'hD3: begin m_rv = 1; m_rd = b; m_ra = 1; end
                    'hD4: begin m_av = 1; m_ad = b; m_mode = m_mode & 'hDF; end
                    default: begin m_kv = 1; m_kd = b; m_mode = m_mode & 'hEF; end
                endcase
                m_arm = 0;
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // compare against the model every cycle
    always @(negedge clk) begin
        if (cmp_on) begin
            chk("R3 mode", int'(mode_o), m_mode);
            chk("R5 outport", int'(outport_o), m_port);
            chk("R9 a20", int'(a20_o), (m_port / 2) % 2);
            chk("R8 sys_reset", int'(sys_reset_o), m_rst);
            chk("R2 reply_valid", int'(reply_valid_o), m_rv);
            if (m_rv != 0) begin
                chk("R6 reply_data", int'(reply_data_o), m_rd);
                chk("R6 reply_aux", int'(reply_aux_o), m_ra);
            end
            chk("R7 kbd_tx_valid", int'(kbd_tx_valid_o), m_kv);
            chk("R7 aux_tx_valid", int'(aux_tx_valid_o), m_av);
            if (m_kv != 0) chk("R7 kbd_tx_data", int'(kbd_tx_data_o), m_kd);
            if (m_av != 0) chk("R7 aux_tx_data", int'(aux_tx_data_o), m_ad);
            chk("R11 rdata", int'(host_rdata), m_rdata);
        end
    end

    task automatic access(input logic sel, input logic wr, input logic rd, input logic [7:0] b);
        @(negedge clk);
        host_sel = sel; host_wr = wr; host_rd = rd; host_wdata = b;
        @(negedge clk);
        host_wr = 1'b0; host_rd = 1'b0;
    endtask

    task automatic wr_cmd(input logic [7:0] b);  access(1'b1, 1'b1, 1'b0, b); endtask
    task automatic wr_data(input logic [7:0] b); access(1'b0, 1'b1, 1'b0, b); endtask
    task automatic rd_status();                  access(1'b1, 1'b0, 1'b1, 8'h00); endtask

    task automatic expect_reply(input string tag, input int d, input int aux);
        chk(tag, int'(reply_valid_o), 1);
        chk(tag, int'(reply_data_o), d);
        chk(tag, int'(reply_aux_o), aux);
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        cmp_on = 1'b1;
        // R1 reset state
        chk("R1 mode", int'(mode_o), 'h03);
        chk("R1 outport", int'(outport_o), 'hCF);
        chk("R1 a20", int'(a20_o), 1);
        chk("R1 strobes", int'({sys_reset_o, reply_valid_o, kbd_tx_valid_o, aux_tx_valid_o}), 0);
        rd_status();
        chk("R1 status", int'(host_rdata), 'h18);

        // R2 replies
        wr_cmd(8'h20); expect_reply("R2 read mode", 'h03, 0);
        wr_cmd(8'hAA); expect_reply("R2 self test", 'h55, 0);
        rd_status();   chk("R2 selftest status", int'(host_rdata), 'h1C);
        wr_cmd(8'hA9); expect_reply("R2 aux test", 'h00, 0);
        wr_cmd(8'hAB); expect_reply("R2 kbd test", 'h00, 0);
        wr_cmd(8'hC0); expect_reply("R2 inport", 'h80, 0);
        wr_cmd(8'hD0); expect_reply("R2 outport", 'hCF, 0);
        @(negedge clk); chk("R2 one cycle", int'(reply_valid_o), 0);

        // R3 mode bits, R7 keyboard forward
        wr_cmd(8'hA7); chk("R3 aux off", int'(mode_o), 'h23);
        wr_cmd(8'hA8); chk("R3 aux on", int'(mode_o), 'h03);
        wr_cmd(8'hAD); chk("R3 kbd off", int'(mode_o), 'h13);
        wr_data(8'h55);
        chk("R7 kbd tx", int'({kbd_tx_valid_o, kbd_tx_data_o}), 'h155);
        chk("R7 kbd re-enable", int'(mode_o), 'h03);
        wr_cmd(8'hAD); wr_cmd(8'hAE); chk("R3 kbd on", int'(mode_o), 'h03);

        // R4 / R5 arming and mode load
        wr_cmd(8'h60);
        chk("R4 arm silent", int'({reply_valid_o, kbd_tx_valid_o, aux_tx_valid_o, sys_reset_o}), 0);
        wr_data(8'h47); chk("R5 mode load", int'(mode_o), 'h47);
        chk("R4 consumed no kbd", int'(kbd_tx_valid_o), 0);
        wr_data(8'h11); chk("R4 disarmed", int'({kbd_tx_valid_o, kbd_tx_data_o}), 'h111);
        wr_cmd(8'h60); wr_cmd(8'h20); expect_reply("R4 reply while armed", 'h47, 0);
        wr_data(8'h01); chk("R4 arm kept", int'(mode_o), 'h01);
        wr_cmd(8'h60); wr_data(8'h03);
        wr_cmd(8'h60); wr_cmd(8'hD2); wr_data(8'h99);
        expect_reply("R4 arm replaced", 'h99, 0);
        chk("R4 mode untouched", int'(mode_o), 'h03);

        // R6 aux reply
        wr_cmd(8'hD3); wr_data(8'h5A); expect_reply("R6 aux reply", 'h5A, 1);

        // R7 aux forward
        wr_cmd(8'hA7); wr_cmd(8'hD4); wr_data(8'h33);
        chk("R7 aux tx", int'({aux_tx_valid_o, aux_tx_data_o}), 'h133);
        chk("R7 aux re-enable", int'(mode_o), 'h03);

        // R9 A20
        wr_cmd(8'hDD); chk("R9 a20 off", int'({a20_o, outport_o}), 'h0CD);
        wr_cmd(8'hDF); chk("R9 a20 on", int'({a20_o, outport_o}), 'h1CF);

        // R5 output port write
        wr_cmd(8'hD1); wr_data(8'hCC);
        chk("R5 port load", int'({a20_o, outport_o}), 'h0CC);
        chk("R5 reset pulse", int'(sys_reset_o), 1);
        @(negedge clk); chk("R5 pulse ends", int'(sys_reset_o), 0);
        wr_cmd(8'hD1); wr_data(8'hCF); chk("R5 no pulse", int'(sys_reset_o), 0);

        // R8 pulse range
        wr_cmd(8'hFE); chk("R8 FE pulse", int'(sys_reset_o), 1);
        chk("R8 port kept", int'(outport_o), 'hCF);
        wr_cmd(8'hF0); chk("R8 F0 pulse", int'(sys_reset_o), 1);
        wr_cmd(8'hFF); chk("R8 FF none", int'(sys_reset_o), 0);
        wr_cmd(8'hF5); chk("R8 F5 none", int'(sys_reset_o), 0);

        // R10 unknown commands
        wr_cmd(8'h00); wr_cmd(8'hB3); wr_cmd(8'h12);
        chk("R10 no strobe", int'({reply_valid_o, kbd_tx_valid_o, aux_tx_valid_o, sys_reset_o}), 0);
        chk("R10 state", int'({mode_o, outport_o}), 'h03CF);
        wr_data(8'h21); chk("R10 not armed", int'(kbd_tx_valid_o), 1);

        // R11 status bit 3
        rd_status(); chk("R11 after data", int'(host_rdata), 'h14);
        wr_cmd(8'h00); rd_status(); chk("R11 after cmd", int'(host_rdata), 'h1C);

        // mixed traffic against the model
        for (int i = 0; i < 400; i++) begin
            int r;
            logic [7:0] b;
            r = int'($urandom % 16);
            b = 8'($urandom);
            if (r < 6) begin
                case (r)
                    0: b = 8'h60; 1: b = 8'hD1; 2: b = 8'hD2;
                    3: b = 8'hD3; 4: b = 8'hD4; default: b = 8'hA7;
                endcase
                if (r == 1) begin wr_cmd(b); wr_data(8'h03 | 8'($urandom)); end
                else wr_cmd(b);
            end else if (r < 11) begin
                wr_data(b);
            end else if (r < 15) begin
                wr_cmd(b);
            end else begin
                rd_status();
            end
        end
        @(negedge clk);
        finish_run();
    end
endmodule